// File: doc/BRIEF.md
# PCI Inbound Window Address Translator

This block sits on the target side of a PCI host bridge. It decides whether an address arriving from the bus belongs to one of the bridge's own windows, and it rewrites that address into a local memory address. There are two memory windows and one I/O window. Each memory window is a fixed 16 MB page. It is matched on address bits 31..24 alone, and it is relocated by a page byte that comes from a separate translation register. Address bits 23..0 pass through unchanged. The I/O window is 256 bytes wide. A hit in it returns the byte offset inside the window.

Configuration software writes and reads five registers through a simple select/write-enable port: a command word, the two memory base registers, the I/O base register and the translation register. Base registers follow the usual sizing convention. After an all-ones write, the read-back shows which bits are fixed, so software can learn the window size and type. The command word holds the enables for I/O response, memory response and bus mastering. Nothing answers until the matching enable is set.

Each lookup request produces a registered result one clock later: a one-cycle hit flag, a window index and the translated address. The response stage is a two-state machine. In `RSP_IDLE` the hit flag is low. In `RSP_HIT` the hit flag is high. The transition IDLE→HIT (and HIT→HIT) is taken when the lookup in the current cycle hits. The transition HIT→IDLE (and IDLE→IDLE) is taken when it misses or no request is present.

Top module: `bar_window_xlate`

## Requirements
- R1: After reset the command word, both memory base registers and the translation register read 0. The I/O base register reads 0x00000001. No lookup hits.
- R2: The command word (select 0) keeps only bits 2..0: bit 0 is I/O response, bit 1 is memory response and bit 2 is bus master. The other bits read 0. `master_en` follows bit 2.
- R3: A memory base register (select 1 for window 0, select 2 for window 1) stores bits 31..24 only. Writing 0xFFFFFFFF reads back 0xFF000000.
- R4: The I/O base register (select 3) stores bits 31..8. Bits 7..1 read 0 and bit 0 reads 1, so writing 0xFFFFFFFF reads back 0xFFFFFF01.
- R5: The translation register (select 4) stores bits 31..16. Bits 31..24 are the local page for window 0 and bits 23..16 are the local page for window 1. Bits 15..0 read 0.
- R6: A memory request hits window k when memory response is enabled and address bits 31..24 equal base register k's bits 31..24. The result is index k (0 or 1) and address {page k, request bits 23..0}. For example, base 0x20000000 with page 0x40 maps 0x20123456 to 0x40123456.
- R7: An I/O request hits when I/O response is enabled and address bits 31..8 equal the I/O base bits 31..8. The result is index 2 and the address request bits 7..0, zero-extended.
- R8: With its enable clear, a window never hits. I/O requests are never compared against memory windows, and memory requests are never compared against the I/O window.
- R9: A miss or an idle cycle gives hit 0, index 0 and address 0 on the following cycle.
- R10: When both memory windows match the same address, window 0 wins.
- R11: A register write and a lookup in the same cycle: the lookup sees the register values from before the write.
- R12: Results appear one cycle after the request. A single request produces exactly one cycle of hit, and requests in back-to-back cycles produce hits in back-to-back cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 3 | Register select (0 command, 1-2 memory bases, 3 I/O base, 4 translation) |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Read-back of the selected register (combinational) |
| req_valid | input | 1 | Lookup request present |
| req_is_io | input | 1 | 1 for an I/O cycle, 0 for a memory cycle |
| req_addr | input | 32 | PCI address of the request |
| hit_o | output | 1 | Registered hit flag, one cycle per hitting request |
| hit_win | output | 2 | Window index: 0 memory window 0, 1 memory window 1, 2 I/O |
| hit_addr | output | 32 | Translated local address |
| master_en | output | 1 | Bus master enable from the command word |

## Verification
Two functions can fall in the same cycle: a configuration write that moves a base register, and a lookup against that same window. The bench provokes this by driving a new base for memory window 0 together with a request that matches only the old base. The request must hit with the old page. In the next cycle, the same upper byte must then hit the other window, which was set to overlap it. A behavioural model in the bench, updated after its prediction at each edge, judges every cycle, and directed checks confirm the expected window and address.

// File: rtl/bwt_pkg.sv
package bwt_pkg;

    localparam int CMD_W   = 3;
    localparam int CMD_IO  = 0;
    localparam int CMD_MEM = 1;
    localparam int CMD_MST = 2;

    typedef enum logic {
        RSP_IDLE = 1'b0,
        RSP_HIT  = 1'b1
    } rsp_state_e;

endpackage

// File: rtl/bwt_regs.sv
module bwt_regs
    import bwt_pkg::*;
#(
    parameter int ADDR_W   = 32,
    parameter int PAGE_LSB = 24,
    parameter int IO_LSB   = 8,
    parameter int NUM_MEM  = 2,
    parameter int SEL_W    = $clog2(NUM_MEM + 3),
    parameter int TAG_W    = ADDR_W - PAGE_LSB
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     cfg_we_i,
    input  logic [SEL_W-1:0]         cfg_sel_i,
    input  logic [ADDR_W-1:0]        cfg_wdata_i,
    output logic [ADDR_W-1:0]        cfg_rdata_o,
    output logic [CMD_W-1:0]         cmd_o,
    output logic [TAG_W-1:0]         mem_tag_o [NUM_MEM],
    output logic [ADDR_W-IO_LSB-1:0] io_tag_o,
    output logic [TAG_W-1:0]         page_o    [NUM_MEM]
);

    localparam int XL_W    = NUM_MEM * TAG_W;
    localparam int XL_PAD  = ADDR_W - XL_W;
    localparam int SEL_IO  = NUM_MEM + 1;
    localparam int SEL_XL  = NUM_MEM + 2;

    logic [CMD_W-1:0]         cmd_q;
    logic [TAG_W-1:0]         mem_tag_q [NUM_MEM];
    logic [ADDR_W-IO_LSB-1:0] io_tag_q;
    logic [XL_W-1:0]          xlat_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_q <= '0;
        end else if (cfg_we_i && cfg_sel_i == '0) begin
            cmd_q <= cfg_wdata_i[CMD_W-1:0];
        end
    end

    genvar g;
    generate
        for (g = 0; g < NUM_MEM; g++) begin : g_mbar
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    mem_tag_q[g] <= '0;
                end else if (cfg_we_i && cfg_sel_i == SEL_W'(g + 1)) begin
                    mem_tag_q[g] <= cfg_wdata_i[ADDR_W-1:PAGE_LSB];
                end
            end
            assign mem_tag_o[g] = mem_tag_q[g];
            assign page_o[g]    = xlat_q[(NUM_MEM-g)*TAG_W-1 -: TAG_W];
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            io_tag_q <= '0;
            xlat_q   <= '0;
        end else if (cfg_we_i) begin
            if (cfg_sel_i == SEL_W'(SEL_IO)) io_tag_q <= cfg_wdata_i[ADDR_W-1:IO_LSB];
            if (cfg_sel_i == SEL_W'(SEL_XL)) xlat_q   <= cfg_wdata_i[ADDR_W-1:XL_PAD];
        end
    end

    always_comb begin
        cfg_rdata_o = '0;
        if (cfg_sel_i == '0) begin
            cfg_rdata_o[CMD_W-1:0] = cmd_q;
        end else if (cfg_sel_i == SEL_W'(SEL_IO)) begin
            cfg_rdata_o = {io_tag_q, {(IO_LSB-1){1'b0}}, 1'b1};
        end else if (cfg_sel_i == SEL_W'(SEL_XL)) begin
            cfg_rdata_o = {xlat_q, {XL_PAD{1'b0}}};
        end else begin
            for (int i = 0; i < NUM_MEM; i++) begin
                if (cfg_sel_i == SEL_W'(i + 1)) cfg_rdata_o = {mem_tag_q[i], {PAGE_LSB{1'b0}}};
            end
        end
    end

    assign cmd_o    = cmd_q;
    assign io_tag_o = io_tag_q;

endmodule

// File: rtl/bwt_match.sv
module bwt_match
    import bwt_pkg::*;
#(
    parameter int ADDR_W   = 32,
    parameter int PAGE_LSB = 24,
    parameter int IO_LSB   = 8,
    parameter int NUM_MEM  = 2,
    parameter int WIN_W    = $clog2(NUM_MEM + 1),
    parameter int TAG_W    = ADDR_W - PAGE_LSB
) (
    input  logic                     req_valid_i,
    input  logic                     req_is_io_i,
    input  logic [ADDR_W-1:0]        req_addr_i,
    input  logic [CMD_W-1:0]         cmd_i,
    input  logic [TAG_W-1:0]         mem_tag_i [NUM_MEM],
    input  logic [ADDR_W-IO_LSB-1:0] io_tag_i,
    input  logic [TAG_W-1:0]         page_i    [NUM_MEM],
    output logic                     hit_o,
    output logic [WIN_W-1:0]         win_o,
    output logic [ADDR_W-1:0]        xaddr_o
);

    logic [NUM_MEM-1:0] mem_match;
    logic               io_match;

    genvar g;
    generate
        for (g = 0; g < NUM_MEM; g++) begin : g_cmp
            assign mem_match[g] = (req_addr_i[ADDR_W-1:PAGE_LSB] == mem_tag_i[g]);
        end
    endgenerate

    assign io_match = (req_addr_i[ADDR_W-1:IO_LSB] == io_tag_i);

    always_comb begin
        hit_o   = 1'b0;
        win_o   = '0;
        xaddr_o = '0;
        if (req_valid_i) begin
            if (req_is_io_i) begin
                if (cmd_i[CMD_IO] && io_match) begin
                    hit_o   = 1'b1;
                    win_o   = WIN_W'(NUM_MEM);
                    xaddr_o = ADDR_W'(req_addr_i[IO_LSB-1:0]);
                end
            end else if (cmd_i[CMD_MEM]) begin
                // descending scan: the lowest matching index is written last and wins
                for (int i = NUM_MEM - 1; i >= 0; i--) begin
                    if (mem_match[i]) begin
                        hit_o   = 1'b1;
                        win_o   = WIN_W'(i);
                        xaddr_o = {page_i[i], req_addr_i[PAGE_LSB-1:0]};
                    end
                end
            end
        end
    end

endmodule

// File: rtl/bwt_resp.sv
module bwt_resp
    import bwt_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int WIN_W  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hit_i,
    input  logic [WIN_W-1:0]  win_i,
    input  logic [ADDR_W-1:0] xaddr_i,
    output logic              hit_o,
    output logic [WIN_W-1:0]  win_o,
    output logic [ADDR_W-1:0] addr_o
);

    rsp_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            RSP_IDLE: state_d = hit_i ? RSP_HIT : RSP_IDLE;
            RSP_HIT:  state_d = hit_i ? RSP_HIT : RSP_IDLE;
            default:  state_d = RSP_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= RSP_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            win_o  <= '0;
            addr_o <= '0;
        end else if (state_d == RSP_HIT) begin
            win_o  <= win_i;
            addr_o <= xaddr_i;
        end else begin
            win_o  <= '0;
            addr_o <= '0;
        end
    end

    assign hit_o = (state_q == RSP_HIT);

endmodule

// File: rtl/bar_window_xlate.sv
module bar_window_xlate
    import bwt_pkg::*;
#(
    parameter int ADDR_W   = 32,
    parameter int PAGE_LSB = 24,
    parameter int IO_LSB   = 8,
    parameter int NUM_MEM  = 2
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              cfg_we,
    input  logic [$clog2(NUM_MEM+3)-1:0]      cfg_sel,
    input  logic [ADDR_W-1:0]                 cfg_wdata,
    output logic [ADDR_W-1:0]                 cfg_rdata,
    input  logic                              req_valid,
    input  logic                              req_is_io,
    input  logic [ADDR_W-1:0]                 req_addr,
    output logic                              hit_o,
    output logic [$clog2(NUM_MEM+1)-1:0]      hit_win,
    output logic [ADDR_W-1:0]                 hit_addr,
    output logic                              master_en
);

    localparam int SEL_W = $clog2(NUM_MEM + 3);
    localparam int WIN_W = $clog2(NUM_MEM + 1);
    localparam int TAG_W = ADDR_W - PAGE_LSB;

    logic [CMD_W-1:0]         cmd_q;
    logic [TAG_W-1:0]         mem_tag [NUM_MEM];
    logic [TAG_W-1:0]         page    [NUM_MEM];
    logic [ADDR_W-IO_LSB-1:0] io_tag;
    logic                     lk_hit;
    logic [WIN_W-1:0]         lk_win;
    logic [ADDR_W-1:0]        lk_addr;

    bwt_regs #(
        .ADDR_W(ADDR_W), .PAGE_LSB(PAGE_LSB), .IO_LSB(IO_LSB),
        .NUM_MEM(NUM_MEM), .SEL_W(SEL_W), .TAG_W(TAG_W)
    ) regs_i (
        .clk(clk), .rst_n(rst_n),
        .cfg_we_i(cfg_we), .cfg_sel_i(cfg_sel), .cfg_wdata_i(cfg_wdata),
        .cfg_rdata_o(cfg_rdata), .cmd_o(cmd_q),
        .mem_tag_o(mem_tag), .io_tag_o(io_tag), .page_o(page)
    );

    bwt_match #(
        .ADDR_W(ADDR_W), .PAGE_LSB(PAGE_LSB), .IO_LSB(IO_LSB),
        .NUM_MEM(NUM_MEM), .WIN_W(WIN_W), .TAG_W(TAG_W)
    ) match_i (
        .req_valid_i(req_valid), .req_is_io_i(req_is_io), .req_addr_i(req_addr),
        .cmd_i(cmd_q), .mem_tag_i(mem_tag), .io_tag_i(io_tag), .page_i(page),
        .hit_o(lk_hit), .win_o(lk_win), .xaddr_o(lk_addr)
    );

    bwt_resp #(
        .ADDR_W(ADDR_W), .WIN_W(WIN_W)
    ) resp_i (
        .clk(clk), .rst_n(rst_n),
        .hit_i(lk_hit), .win_i(lk_win), .xaddr_i(lk_addr),
        .hit_o(hit_o), .win_o(hit_win), .addr_o(hit_addr)
    );

    assign master_en = cmd_q[CMD_MST];

endmodule

// File: rtl/bar_window_xlate_chk.sv
module bar_window_xlate_chk
    import bwt_pkg::*;
#(
    parameter int ADDR_W   = 32,
    parameter int PAGE_LSB = 24,
    parameter int IO_LSB   = 8,
    parameter int NUM_MEM  = 2
) (
    input logic                         clk,
    input logic                         rst_n,
    input logic                         req_valid,
    input logic                         req_is_io,
    input logic [ADDR_W-1:0]            req_addr,
    input logic                         hit_o,
    input logic [$clog2(NUM_MEM+1)-1:0] hit_win,
    input logic [ADDR_W-1:0]            hit_addr,
    input logic [CMD_W-1:0]             cmd_bits
);

    localparam int WIN_W = $clog2(NUM_MEM + 1);

    assert_one_cycle_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(req_valid) |-> !hit_o);

    assert_miss_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !hit_o |-> (hit_win == '0 && hit_addr == '0));

    assert_io_gate_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (hit_o && hit_win == WIN_W'(NUM_MEM)) |-> ($past(cmd_bits[CMD_IO]) && $past(req_is_io)));

    assert_mem_gate_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (hit_o && hit_win < WIN_W'(NUM_MEM)) |-> ($past(cmd_bits[CMD_MEM]) && !$past(req_is_io)));

    assert_pass_low_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (hit_o && hit_win < WIN_W'(NUM_MEM)) |->
            hit_addr[PAGE_LSB-1:0] == $past(req_addr[PAGE_LSB-1:0]));

    assert_io_offset_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (hit_o && hit_win == WIN_W'(NUM_MEM)) |->
            (hit_addr[ADDR_W-1:IO_LSB] == '0 && hit_addr[IO_LSB-1:0] == $past(req_addr[IO_LSB-1:0])));

    assert_win_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
        hit_o |-> hit_win <= WIN_W'(NUM_MEM));

endmodule

bind bar_window_xlate bar_window_xlate_chk #(
    .ADDR_W(ADDR_W), .PAGE_LSB(PAGE_LSB), .IO_LSB(IO_LSB), .NUM_MEM(NUM_MEM)
) chk_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_is_io(req_is_io),
    .req_addr(req_addr), .hit_o(hit_o), .hit_win(hit_win), .hit_addr(hit_addr),
    .cmd_bits(cmd_q)
);

// File: tb/bar_window_xlate_tb_top.sv
module bar_window_xlate_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [2:0]  cfg_sel = '0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_rdata;
    logic        req_valid = 1'b0;
    logic        req_is_io = 1'b0;
    logic [31:0] req_addr = '0;
    logic        hit_o;
    logic [1:0]  hit_win;
    logic [31:0] hit_addr;
    logic        master_en;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    always #5 clk = ~clk;

    bar_window_xlate dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .req_valid(req_valid),
        .req_is_io(req_is_io), .req_addr(req_addr), .hit_o(hit_o),
        .hit_win(hit_win), .hit_addr(hit_addr), .master_en(master_en)
    );

    // behavioural reference: register contents as software sees them
    logic [31:0] m_cmd, m_mbar0, m_mbar1, m_iobar, m_xlat;
    logic        e_hit;
    logic [1:0]  e_win;
    logic [31:0] e_addr;

    function automatic logic [31:0] model_read(input logic [2:0] s);
        case (s)
            3'd0: return m_cmd;
            3'd1: return m_mbar0;
            3'd2: return m_mbar1;
            3'd3: return m_iobar;
            3'd4: return m_xlat;
            default: return 32'h0;
        endcase
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_cmd = 0; m_mbar0 = 0; m_mbar1 = 0; m_iobar = 32'h1; m_xlat = 0;
            e_hit = 0; e_win = 0; e_addr = 0;
        end else begin
            e_hit = 0; e_win = 0; e_addr = 0;
            if (req_valid && req_is_io && m_cmd[0] && req_addr[31:8] == m_iobar[31:8]) begin
                e_hit = 1; e_win = 2; e_addr = {24'h0, req_addr[7:0]};
            end else if (req_valid && !req_is_io && m_cmd[1]) begin
                if (req_addr[31:24] == m_mbar0[31:24]) begin
                    e_hit = 1; e_win = 0; e_addr = {m_xlat[31:24], req_addr[23:0]};
                end else if (req_addr[31:24] == m_mbar1[31:24]) begin
                    e_hit = 1; e_win = 1; e_addr = {m_xlat[23:16], req_addr[23:0]};
                end
            end
            if (cfg_we) begin
                case (cfg_sel)
                    3'd0: m_cmd   = {29'h0, cfg_wdata[2:0]};
                    3'd1: m_mbar0 = {cfg_wdata[31:24], 24'h0};
                    3'd2: m_mbar1 = {cfg_wdata[31:24], 24'h0};
                    3'd3: m_iobar = {cfg_wdata[31:8], 8'h01};
                    3'd4: m_xlat  = {cfg_wdata[31:16], 16'h0};
                    default: ;
                endcase
            end
        end
    end

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
        end
    endtask

    // per-cycle comparison against the model, away from the active edge
    always @(negedge clk) begin
        #1;
        if (rst_n && !done) begin
            check("R12 hit flag", {31'h0, hit_o}, {31'h0, e_hit});
            check("R10 window index", {30'h0, hit_win}, {30'h0, e_win});
            check("R6 translated address", hit_addr, e_addr);
            check("R2 master enable", {31'h0, master_en}, {31'h0, m_cmd[2]});
            check("R5 register read-back", cfg_rdata, model_read(cfg_sel));
        end
    end

    task automatic wr(input logic [2:0] s, input logic [31:0] d);
        @(negedge clk);
        cfg_we = 1; cfg_sel = s; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 0;
    endtask

    task automatic rd(input string tag, input logic [2:0] s, input logic [31:0] exp);
        @(negedge clk);
        cfg_sel = s;
        #2;
        check(tag, cfg_rdata, exp);
    endtask

    task automatic look(input string tag, input logic io, input logic [31:0] a,
                        input logic eh, input logic [1:0] ew, input logic [31:0] ea);
        @(negedge clk);
        req_valid = 1; req_is_io = io; req_addr = a;
        @(negedge clk);
        req_valid = 0;
        #2;
        check(tag, {31'h0, hit_o}, {31'h0, eh});
        check(tag, {30'h0, hit_win}, {30'h0, ew});
        check(tag, hit_addr, ea);
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R1 reset state
        rd("R1 command", 3'd0, 32'h0);
        rd("R1 mem base 0", 3'd1, 32'h0);
        rd("R1 mem base 1", 3'd2, 32'h0);
        rd("R1 io base", 3'd3, 32'h1);
        rd("R1 translation", 3'd4, 32'h0);
        look("R1 no response before enable", 1'b0, 32'h00000010, 0, 0, 0);
        // sizing
        wr(3'd1, 32'hFFFFFFFF);
        rd("R3 mem sizing", 3'd1, 32'hFF000000);
        wr(3'd3, 32'hFFFFFFFF);
        rd("R4 io sizing", 3'd3, 32'hFFFFFF01);
        wr(3'd0, 32'hFFFFFFFF);
        rd("R2 command mask", 3'd0, 32'h7);
        total++; if (master_en !== 1'b1) begin bad++; $display("FAIL R2 master_en actual=%b expected=1", master_en); end
        // configure windows
        wr(3'd1, 32'h20000000);
        wr(3'd2, 32'h30ABCDEF);
        wr(3'd3, 32'hA00000FF);
        wr(3'd4, 32'h40A51234);
        rd("R5 translation", 3'd4, 32'h40A50000);
        rd("R3 mem base 1 low bits", 3'd2, 32'h30000000);
        wr(3'd0, 32'h3);
        total++; if (master_en !== 1'b0) begin bad++; $display("FAIL R2 master_en actual=%b expected=0", master_en); end
        look("R6 window 0", 1'b0, 32'h20123456, 1, 0, 32'h40123456);
        look("R6 window 1", 1'b0, 32'h30FFFFFF, 1, 1, 32'hA5FFFFFF);
        look("R7 io hit", 1'b1, 32'hA00000C4, 1, 2, 32'h000000C4);
        look("R9 io just past window", 1'b1, 32'hA0000100, 0, 0, 0);
        look("R8 mem request at io address", 1'b0, 32'hA0000000, 0, 0, 0);
        look("R8 io request at mem address", 1'b1, 32'h20000000, 0, 0, 0);
        wr(3'd0, 32'h2);
        look("R8 io disabled", 1'b1, 32'hA0000010, 0, 0, 0);
        look("R8 mem still enabled", 1'b0, 32'h20000004, 1, 0, 32'h40000004);
        wr(3'd0, 32'h1);
        look("R8 mem disabled", 1'b0, 32'h20000000, 0, 0, 0);
        look("R8 io still enabled", 1'b1, 32'hA0000001, 1, 2, 32'h00000001);
        wr(3'd0, 32'h3);
        // R10 overlap priority
        wr(3'd2, 32'h20000000);
        look("R10 overlap picks window 0", 1'b0, 32'h20000008, 1, 0, 32'h40000008);
        // R11 write and lookup in the same cycle
        @(negedge clk);
        cfg_we = 1; cfg_sel = 3'd1; cfg_wdata = 32'h50000000;
        req_valid = 1; req_is_io = 0; req_addr = 32'h20000010;
        @(negedge clk);
        cfg_we = 0; req_valid = 0;
        #2;
        check("R11 old base used", hit_addr, 32'h40000010);
        check("R11 old window", {30'h0, hit_win}, 32'h0);
        look("R11 overlap now window 1", 1'b0, 32'h20000020, 1, 1, 32'hA5000020);
        look("R11 new base", 1'b0, 32'h50000000, 1, 0, 32'h40000000);
        // R12 back-to-back then idle
        @(negedge clk);
        req_valid = 1; req_is_io = 1; req_addr = 32'hA0000011;
        @(negedge clk);
        req_is_io = 0; req_addr = 32'h50000022;
        #2;
        check("R12 first of pair", hit_addr, 32'h00000011);
        @(negedge clk);
        req_valid = 0;
        #2;
        check("R12 second of pair", hit_addr, 32'h40000022);
        @(negedge clk);
        #2;
        check("R12 single cycle hit", {31'h0, hit_o}, 32'h0);
        repeat (2) @(negedge clk);
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule